// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Model

This block is a synthesizable behavioural model of a pipelined synchronous burst SRAM with a small internal array. It samples every control and data input on the rising clock edge. A new external address is taken from either of two load strobes: a processor strobe, which counts only while the primary active-low select is low, and a controller strobe. Once an address is loaded, the block continues a burst on each later cycle. The advance input steps the low two address bits, or holds them to insert a wait state. Each cycle is a read or a write, set by a global write override, a byte-write master enable and one enable for each of four byte lanes. Each lane holds eight data bits, plus a parity bit when parity is configured.

Read data leaves through one output register, so a word becomes valid one clock after its address is registered. The output enable gates the drivers without waiting for a clock. The doze input freezes the block: no write takes place, the outputs turn off and the array keeps its contents. The control core is a four-state machine: DESEL (deselected), READ, WRITE and SLEEP. The transitions are LOAD_RD and LOAD_WR (a load with all three selects true), LOAD_OFF (a load with any select false, which goes to DESEL), CONT (a burst step or hold from READ or WRITE), ENTER_DOZE (any state to SLEEP while doze is high) and WAKE (SLEEP to DESEL once doze drops). With no load, DESEL stays where it is.

Top module: `bsram_top`

## Requirements
- R1: While reset is held and on the first cycle after it, the state is DESEL and `dout_en` is 0, so `dout` reads 0 even with `out_en_n` low.
- R2: With `wr_all_n` low on a write cycle, all four lanes of the addressed word take `din`, whatever `wr_byte_n` and `lane_n` are.
- R3: With `wr_all_n` high, lane i is written only when `wr_byte_n` is low and `lane_n[i]` is low. With `wr_byte_n` high, or with all of `lane_n` high, the cycle is a read and the array is unchanged.
- R4: Lane i occupies bits `[i*LW +: LW]` of `din`/`dout`, with LW = 9 when parity is enabled (the parity bit is the top bit of the lane) and LW = 8 otherwise. So `lane_n[0]` controls bits 8:0 in the default build.
- R5: A word whose read address is registered at clock edge k is driven on `dout` with `dout_en` high after edge k+1. After edge k alone, output that was off stays off.
- R6: The three selects (`sel_n`, `sel2_n` active low, `sel_hi` active high) are sampled only on load cycles. A load with any of them false moves to DESEL, and the output turns off after the following edge. Changes to the selects during burst continuation are ignored.
- R7: `ld_cpu_n` loads an address only when `sel_n` is low. `ld_cpu_n` low with `sel_n` high is ignored, and the burst in progress continues.
- R8: With `step_n` low on a continuation cycle, address bits 1:0 increment linearly and wrap inside their group of four (for example 10, 11, 8, 9). The upper address bits are unchanged.
- R9: With `step_n` high on a continuation cycle, the address is held, and the same word is read (or written) again as a wait state.
- R10: A load through `ld_cpu_n` is always a read, whatever the write enables are. A write in the next cycle goes to the loaded address if `step_n` is high, and to the stepped address if `step_n` is low.
- R11: While `doze` is high, no array write occurs, `dout_en` is 0 and all other inputs are ignored. Array contents are retained, and after `doze` falls the block is DESEL until a new load.
- R12: `out_en_n` acts without a clock: when it is high, `dout_en` is 0 and `dout` is 0. When it is low again, the registered word reappears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all sampled inputs |
| rst_n | input | 1 | Active-low asynchronous reset of the control state (not the array) |
| addr | input | ADDR_W | External word address |
| ld_cpu_n | input | 1 | Processor load strobe, honoured only with `sel_n` low |
| ld_ctl_n | input | 1 | Controller load strobe |
| step_n | input | 1 | Burst advance; high inserts a wait state |
| sel_n | input | 1 | Active-low select, sampled on loads |
| sel_hi | input | 1 | Active-high select, sampled on loads |
| sel2_n | input | 1 | Second active-low select, sampled on loads |
| wr_all_n | input | 1 | Global write override, all lanes |
| wr_byte_n | input | 1 | Byte-write master enable |
| lane_n | input | 4 | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| doze | input | 1 | Retention standby request, active high |
| din | input | 4*LW | Write data, four lanes |
| dout | output | 4*LW | Read data, 0 when not driven |
| dout_en | output | 1 | High when `dout` carries a valid word |

## Verification
The bench runs a burst that starts at address 10 and checks for the wrap order 10, 11, 8, 9. A counter that carried into bit 2 would return the word at 12 instead. Select changes and a processor strobe with `sel_n` high are applied during a running burst. A design that sampled selects on every cycle, or that honoured the ungated strobe, would turn the output off or jump to a new address. A processor-strobe load is driven with the global write asserted and junk data, and the stored word is then read back unchanged. The cycle after that load writes with and without advance. A design that wrote on the load cycle, or that ignored the advance, leaves the wrong word in the array. Doze is raised during a write attempt, and the bench checks for data retention and for the block staying deselected after doze falls. A design that kept writing, or that resumed the burst, would corrupt the word or drive stale data.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    // Control state: what the most recent clock edge decided.
    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_SLEEP = 2'd3
    } bs_state_e;

    localparam int BS_LANES = 4;

endpackage

// File: rtl/bsram_wrdec.sv
module bsram_wrdec #(
    parameter int LANES = 4
) (
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] lane_we,
    output logic             any_we
);

    // Global write overrides; otherwise master AND per-lane enable.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = !wr_all_n || (!wr_byte_n && !lane_n[g]);
    end

    assign any_we = |lane_we;

endmodule

// File: rtl/bsram_seq.sv
module bsram_seq
    import bsram_pkg::*;
#(
    parameter int AW = 6,
    parameter int BB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          doze,
    input  logic          ld_cpu_n,
    input  logic          ld_ctl_n,
    input  logic          step_n,
    input  logic          sel_n,
    input  logic          sel_hi,
    input  logic          sel2_n,
    input  logic          any_we,
    input  logic [AW-1:0] addr,
    output bs_state_e     state_q,
    output logic [AW-1:0] addr_q,
    output logic          wr_go,
    output logic [AW-1:0] wr_addr
);

    localparam logic [BB-1:0] STEP_ONE = BB'(1);

    bs_state_e     nxt_state;
    logic [AW-1:0] nxt_addr;
    logic [AW-1:0] step_addr;
    logic [AW-1:0] eff_addr;
    logic          cpu_load;
    logic          ctl_load;
    logic          sel_ok;

    assign cpu_load  = !ld_cpu_n && !sel_n;
    assign ctl_load  = !ld_ctl_n;
    assign sel_ok    = !sel_n && sel_hi && !sel2_n;
    assign step_addr = {addr_q[AW-1:BB], addr_q[BB-1:0] + STEP_ONE};
    assign eff_addr  = step_n ? addr_q : step_addr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
            addr_q  <= '0;
        end else begin
            state_q <= nxt_state;
            addr_q  <= nxt_addr;
        end
    end

    // Next state and outputs
    always_comb begin
        nxt_state = state_q;
        nxt_addr  = addr_q;
        wr_go     = 1'b0;
        wr_addr   = addr_q;
        if (doze) begin
            nxt_state = ST_SLEEP;                       // ENTER_DOZE
        end else if (cpu_load || ctl_load) begin
            if (!sel_ok) begin
                nxt_state = ST_DESEL;                   // LOAD_OFF
            end else begin
                nxt_addr = addr;
                if (!cpu_load && any_we) begin
                    nxt_state = ST_WRITE;               // LOAD_WR
                    wr_go     = 1'b1;
                    wr_addr   = addr;
                end else begin
                    nxt_state = ST_READ;                // LOAD_RD
                end
            end
        end else begin
            unique case (state_q)
                ST_READ, ST_WRITE: begin                // CONT
                    nxt_addr = eff_addr;
                    if (any_we) begin
                        nxt_state = ST_WRITE;
                        wr_go     = 1'b1;
                        wr_addr   = eff_addr;
                    end else begin
                        nxt_state = ST_READ;
                    end
                end
                ST_SLEEP: nxt_state = ST_DESEL;         // WAKE
                ST_DESEL: nxt_state = ST_DESEL;
            endcase
        end
    end

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int AW    = 6,
    parameter int LANES = 4,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                doze,
    input  logic                wr_go,
    input  logic [AW-1:0]       wr_addr,
    input  logic [LANES-1:0]    lane_we,
    input  logic [LANES*LW-1:0] din,
    input  logic                rd_go,
    input  logic [AW-1:0]       rd_addr,
    output logic [LANES*LW-1:0] dout_q,
    output logic                drv_q
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] lane_mem [DEPTH];
        logic [LW-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (wr_go && lane_we[g] && !doze) begin
                lane_mem[wr_addr] <= din[g*LW +: LW];
            end
            if (rd_go && !doze) begin
                lane_q <= lane_mem[rd_addr];
            end
        end

        assign dout_q[g*LW +: LW] = lane_q;
    end

    // Output register stage: valid one edge after the read address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= 1'b0;
        end else begin
            drv_q <= rd_go && !doze;
        end
    end

endmodule

// File: rtl/bsram_top.sv
module bsram_top
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int PARITY = 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic                               ld_cpu_n,
    input  logic                               ld_ctl_n,
    input  logic                               step_n,
    input  logic                               sel_n,
    input  logic                               sel_hi,
    input  logic                               sel2_n,
    input  logic                               wr_all_n,
    input  logic                               wr_byte_n,
    input  logic [3:0]                         lane_n,
    input  logic                               out_en_n,
    input  logic                               doze,
    input  logic [4*((PARITY != 0) ? 9 : 8)-1:0] din,
    output logic [4*((PARITY != 0) ? 9 : 8)-1:0] dout,
    output logic                               dout_en
);

    localparam int LW    = (PARITY != 0) ? 9 : 8;
    localparam int LANES = BS_LANES;
    localparam int DW    = LANES * LW;
    localparam int BB    = 2;

    bs_state_e         state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] wr_addr;
    logic              wr_go;
    logic [LANES-1:0]  lane_we;
    logic              any_we;
    logic [DW-1:0]     dout_q;
    logic              drv_q;
    logic              rd_go;

    bsram_wrdec #(.LANES(LANES)) u_wrdec (
        .wr_all_n  (wr_all_n),
        .wr_byte_n (wr_byte_n),
        .lane_n    (lane_n),
        .lane_we   (lane_we),
        .any_we    (any_we)
    );

    bsram_seq #(.AW(ADDR_W), .BB(BB)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .doze     (doze),
        .ld_cpu_n (ld_cpu_n),
        .ld_ctl_n (ld_ctl_n),
        .step_n   (step_n),
        .sel_n    (sel_n),
        .sel_hi   (sel_hi),
        .sel2_n   (sel2_n),
        .any_we   (any_we),
        .addr     (addr),
        .state_q  (state_q),
        .addr_q   (addr_q),
        .wr_go    (wr_go),
        .wr_addr  (wr_addr)
    );

    assign rd_go = (state_q == ST_READ);

    bsram_array #(.AW(ADDR_W), .LANES(LANES), .LW(LW)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .doze    (doze),
        .wr_go   (wr_go),
        .wr_addr (wr_addr),
        .lane_we (lane_we),
        .din     (din),
        .rd_go   (rd_go),
        .rd_addr (addr_q),
        .dout_q  (dout_q),
        .drv_q   (drv_q)
    );

    // Asynchronous output gating
    assign dout_en = drv_q && !out_en_n && !doze;
    assign dout    = dout_en ? dout_q : '0;

endmodule

// File: rtl/bsram_chk.sv
module bsram_chk
    import bsram_pkg::*;
#(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          doze,
    input logic          ld_cpu_n,
    input logic          ld_ctl_n,
    input logic          step_n,
    input logic          sel_n,
    input logic          sel_hi,
    input logic          sel2_n,
    input logic          out_en_n,
    input logic          dout_en,
    input bs_state_e     state_q,
    input logic [AW-1:0] addr_q,
    input logic          wr_go,
    input logic          drv_q
);

    logic any_load;
    logic cont;
    assign any_load = (!ld_cpu_n && !sel_n) || !ld_ctl_n;
    assign cont     = !doze && !any_load &&
                      (state_q == ST_READ || state_q == ST_WRITE);

    p_reset_state_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (state_q == ST_DESEL) && !drv_q);

    p_read_pipe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!doze && state_q == ST_READ) |=> drv_q);

    p_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_READ) |=> !drv_q);

    p_load_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!doze && any_load && !(!sel_n && sel_hi && !sel2_n)) |=> state_q == ST_DESEL);

    p_cpu_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!doze && !ld_cpu_n && sel_n && ld_ctl_n && state_q == ST_READ) |=> state_q != ST_DESEL);

    p_step_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && !step_n) |=>
        (addr_q[AW-1:2] == $past(addr_q[AW-1:2])) && (addr_q[1:0] == $past(addr_q[1:0]) + 2'd1));

    p_wait_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && step_n) |=> $stable(addr_q));

    p_cpu_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!doze && !ld_cpu_n && !sel_n) |-> !wr_go);

    p_doze_nowr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        doze |-> !wr_go);

    p_doze_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        doze |=> !drv_q && state_q == ST_SLEEP);

    p_oe_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> !out_en_n && !doze);

endmodule

bind bsram_top bsram_chk #(.AW(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .doze     (doze),
    .ld_cpu_n (ld_cpu_n),
    .ld_ctl_n (ld_ctl_n),
    .step_n   (step_n),
    .sel_n    (sel_n),
    .sel_hi   (sel_hi),
    .sel2_n   (sel2_n),
    .out_en_n (out_en_n),
    .dout_en  (dout_en),
    .state_q  (state_q),
    .addr_q   (addr_q),
    .wr_go    (wr_go),
    .drv_q    (drv_q)
);

// File: tb/tb_bsram_top.sv
module tb_bsram_top;

    localparam int AW = 6;
    localparam int LW = 9;
    localparam int DW = 4 * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr;
    logic          ld_cpu_n, ld_ctl_n, step_n, sel_n, sel_hi, sel2_n;
    logic          wr_all_n, wr_byte_n, out_en_n, doze;
    logic [3:0]    lane_n;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dout_en;

    logic [DW-1:0] sh [1 << AW];
    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bsram_top #(.ADDR_W(AW), .PARITY(1)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ld_cpu_n(ld_cpu_n), .ld_ctl_n(ld_ctl_n),
        .step_n(step_n), .sel_n(sel_n), .sel_hi(sel_hi), .sel2_n(sel2_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
        .out_en_n(out_en_n), .doze(doze), .din(din), .dout(dout), .dout_en(dout_en)
    );

    task automatic idle();
        addr = '0; ld_cpu_n = 1; ld_ctl_n = 1; step_n = 1;
        sel_n = 0; sel_hi = 1; sel2_n = 0;
        wr_all_n = 1; wr_byte_n = 1; lane_n = 4'hF;
        out_en_n = 0; doze = 0; din = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic desel();
        idle(); ld_ctl_n = 0; sel_n = 1; tick(); idle();
    endtask

    // Controller-strobe load with the given write controls, then deselect.
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic g, input logic m, input logic [3:0] l);
        idle(); ld_ctl_n = 0; addr = a; din = d;
        wr_all_n = g; wr_byte_n = m; lane_n = l;
        tick();
        for (int i = 0; i < 4; i++)
            if (!g || (!m && !l[i])) sh[a][i*LW +: LW] = d[i*LW +: LW];
        desel();
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic en);
        idle(); ld_ctl_n = 0; addr = a; tick(); idle(); tick();
        d = dout; en = dout_en;
        desel();
    endtask

    task automatic t_reset();
        chk("R1 reset dout_en", DW'(dout_en), DW'(0));
        chk("R1 reset dout", dout, '0);
    endtask

    task automatic t_writes();
        logic [DW-1:0] d; logic en;
        wr(6'd5, 36'h1_2345_6789, 1'b0, 1'b1, 4'hF);
        rd(6'd5, d, en);
        chk("R2 global write all lanes", d, sh[5]);
        chk("R2 read drives", DW'(en), DW'(1));
        wr(6'd5, 36'hA_BCDE_F012, 1'b1, 1'b0, 4'b1010);
        rd(6'd5, d, en);
        chk("R3 lanes 0 and 2 written", d, sh[5]);
        wr(6'd5, 36'hF_FFFF_FFFF, 1'b1, 1'b1, 4'h0);
        rd(6'd5, d, en);
        chk("R3 master high no write", d, sh[5]);
        wr(6'd5, 36'h0_0000_0000, 1'b1, 1'b0, 4'hF);
        rd(6'd5, d, en);
        chk("R3 all lanes off no write", d, sh[5]);
        wr(6'd5, 36'hF_FFFF_FFFF, 1'b1, 1'b0, 4'b1110);
        rd(6'd5, d, en);
        chk("R4 lane0 bits 8:0 incl parity", d, {sh[5][35:9], 9'h1FF});
    endtask

    task automatic t_latency();
        idle(); ld_ctl_n = 0; addr = 6'd5; tick();
        idle();
        chk("R5 off after load edge", DW'(dout_en), DW'(0));
        tick();
        chk("R5 valid after second edge", dout, sh[5]);
        desel();
    endtask

    task automatic t_burst();
        for (int i = 8; i < 12; i++) wr(AW'(i), DW'(36'h100 + i * 36'h1_0101), 1'b0, 1'b1, 4'hF);
        idle(); ld_ctl_n = 0; addr = 6'd10; tick();
        idle(); step_n = 0;
        tick(); chk("R8 burst word 10", dout, sh[10]);
        tick(); chk("R8 burst word 11", dout, sh[11]);
        tick(); chk("R8 wrap to 8", dout, sh[8]);
        tick(); chk("R8 word 9", dout, sh[9]);
        desel();
        idle(); ld_ctl_n = 0; addr = 6'd8; tick();
        idle(); step_n = 0; tick();
        step_n = 1; tick(); chk("R9 word 9", dout, sh[9]);
        tick(); chk("R9 wait state repeats 9", dout, sh[9]);
        step_n = 0; tick(); tick(); chk("R9 resume at 10", dout, sh[10]);
        desel();
    endtask

    task automatic t_select();
        idle(); ld_ctl_n = 0; addr = 6'd8; tick();
        idle(); step_n = 0; sel_n = 1; sel_hi = 0; sel2_n = 1;
        tick(); chk("R6 selects ignored in burst", dout, sh[8]);
        tick(); chk("R6 burst continues", dout, sh[9]);
        idle(); ld_cpu_n = 0; sel_n = 1; addr = 6'd5;
        tick(); chk("R7 gated strobe ignored", DW'(dout_en), DW'(1));
        tick(); chk("R7 same word held", dout, sh[10]);
        idle(); ld_cpu_n = 0; addr = 6'd5; tick();
        idle(); tick(); chk("R7 cpu strobe loads", dout, sh[5]);
        idle(); ld_ctl_n = 0; sel_hi = 0; tick();
        idle(); tick(); chk("R6 deselect turns output off", DW'(dout_en), DW'(0));
    endtask

    task automatic t_cpu_write();
        logic [DW-1:0] d; logic en;
        wr(6'd21, 36'h5_5555_5555, 1'b0, 1'b1, 4'hF);
        idle(); ld_cpu_n = 0; addr = 6'd21; wr_all_n = 0; din = 36'hD_EAD0_BEEF; tick();
        desel();
        rd(6'd21, d, en);
        chk("R10 cpu load does not write", d, sh[21]);
        idle(); ld_cpu_n = 0; addr = 6'd20; tick();
        idle(); wr_all_n = 0; din = 36'h3_3C3C_3C3C; tick();
        sh[20] = 36'h3_3C3C_3C3C;
        desel();
        rd(6'd20, d, en);
        chk("R10 write at loaded address", d, sh[20]);
        idle(); ld_cpu_n = 0; addr = 6'd24; tick();
        idle(); step_n = 0; wr_all_n = 0; din = 36'h7_1234_4321; tick();
        sh[25] = 36'h7_1234_4321;
        desel();
        rd(6'd25, d, en);
        chk("R10 advance writes next address", d, sh[25]);
    endtask

    task automatic t_doze();
        logic [DW-1:0] d; logic en;
        idle(); ld_ctl_n = 0; addr = 6'd5; tick();
        idle(); tick();
        doze = 1; ld_ctl_n = 0; addr = 6'd5; wr_all_n = 0; din = 36'h0_F0F0_F0F0;
        #1 chk("R11 doze output off", DW'(dout_en), DW'(0));
        tick(); tick();
        chk("R11 doze stays off", DW'(dout_en), DW'(0));
        idle(); tick(); tick();
        chk("R11 deselected after wake", DW'(dout_en), DW'(0));
        rd(6'd5, d, en);
        chk("R11 contents retained", d, sh[5]);
    endtask

    task automatic t_oe();
        idle(); ld_ctl_n = 0; addr = 6'd9; tick();
        idle(); tick();
        out_en_n = 1;
        #1 chk("R12 oe high disables", DW'(dout_en), DW'(0));
        chk("R12 oe high zero data", dout, '0);
        out_en_n = 0;
        #1 chk("R12 oe low restores", dout, sh[9]);
        desel();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) sh[i] = '0;
        idle();
        @(negedge clk); @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_writes();
        t_latency();
        t_burst();
        t_select();
        t_cpu_write();
        t_doze();
        t_oe();
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule